// File: doc/BRIEF.md
# Taint-Tracking Operator Datapath

This combinational datapath applies one chosen operation to two data words and returns the result together with a per-bit taint vector. Every data bit travels with a shadow bit that marks it as untrusted. The operations are bitwise AND, OR and XOR, a two-way select driven by a one-bit select with its own taint bit, and addition modulo 2^W.

A policy input chooses how taint moves through the operation. The conservative policy taints an output bit whenever any input feeding it is tainted. The precise policy looks at the operator. It drops taint that cannot affect the value: a trusted controlling value on AND or OR, and an untrusted select whose data paths are clean. The data result never depends on the policy. Only the taint vector does.

A security checker can place the block beside a functional datapath to label results. It can also run both policies on the same traffic to measure how many false taint marks the conservative policy reports.

Top module: `tnt_opdp`

## Requirements
- R1: A taint bit of 1 marks the bit untrusted and 0 marks it trusted. When no input carries taint (both operand taint vectors zero and the select taint zero), the result taint is all zero for every opcode and policy.
- R2: Conservative policy (`precise`=0) for AND and OR: taint bit i is `a_taint[i] | b_taint[i]`. For ADD: every taint bit is 1 when any operand taint bit is 1, and all are 0 otherwise.
- R3: Precise policy (`precise`=1) for AND: when either operand bit i is 0 and trusted, result bit i is 0 and trusted. Otherwise it carries `a_taint[i] | b_taint[i]`.
- R4: Precise policy for OR: when either operand bit i is 1 and trusted, result bit i is 1 and trusted. Otherwise it carries `a_taint[i] | b_taint[i]`.
- R5: For XOR, taint bit i is `a_taint[i] | b_taint[i]` under both policies.
- R6: Conservative policy for MUX: taint bit i is `sel_taint | a_taint[i] | b_taint[i]`. A tainted select therefore taints every bit, even with clean data.
- R7: Precise policy for MUX: the result taint equals the taint vector of the selected operand (`b_taint` when `sel`=1, `a_taint` when `sel`=0), whatever `sel_taint` is.
- R8: Precise policy for ADD: taint bit i is 1 exactly when some operand taint bit at position i or lower is 1.
- R9: Opcode encoding is 0 AND, 1 OR, 2 XOR, 3 MUX (`sel`=1 picks `op_b`, `sel`=0 picks `op_a`), 4 ADD (sum modulo 2^W). The data result is identical under both policies.
- R10: Opcodes 5, 6 and 7 return zero data and zero taint.
- R11: For every input, the precise taint vector never has a 1 where the conservative taint vector has a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand data |
| op_a_taint | input | W | Taint vector of op_a |
| op_b | input | W | Second operand data |
| op_b_taint | input | W | Taint vector of op_b |
| sel | input | 1 | Select for MUX (1 picks op_b) |
| sel_taint | input | 1 | Taint bit of sel |
| opcode | input | 3 | Operation code |
| precise | input | 1 | 1 = precise policy, 0 = conservative |
| res | output | W | Data result |
| res_taint | output | W | Taint vector of the result |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle as the input that exposes it. A wrong policy term shows up only as a taint bit that differs on specific bit patterns: a trusted zero under AND, a trusted one under OR, a tainted select with clean data, or one low tainted bit under ADD. The bench aims directed vectors at each of these patterns and replays every random vector under both policies, so a result that changes with the policy is caught.

// File: rtl/tnt_pkg.sv
package tnt_pkg;
  localparam int OP_BITS = 3;

  typedef enum logic [OP_BITS-1:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_MUX = 3'd3,
    OP_ADD = 3'd4
  } tnt_op_e;
endpackage

// File: rtl/tnt_bitwise_unit.sv
module tnt_bitwise_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] b,
  input  logic [W-1:0] b_t,
  output logic [W-1:0] and_d,
  output logic [W-1:0] and_tc,
  output logic [W-1:0] and_tp,
  output logic [W-1:0] or_d,
  output logic [W-1:0] or_tc,
  output logic [W-1:0] or_tp,
  output logic [W-1:0] xor_d,
  output logic [W-1:0] xor_t
);
  // A trusted controlling value on either side decides the bit alone.
  function automatic logic [W-1:0] and_precise(input logic [W-1:0] x, xt, y, yt);
    logic [W-1:0] x_kills, y_kills;
    x_kills = ~x & ~xt;
    y_kills = ~y & ~yt;
    return (xt | yt) & ~x_kills & ~y_kills;
  endfunction

  function automatic logic [W-1:0] or_precise(input logic [W-1:0] x, xt, y, yt);
    logic [W-1:0] x_forces, y_forces;
    x_forces = x & ~xt;
    y_forces = y & ~yt;
    return (xt | yt) & ~x_forces & ~y_forces;
  endfunction

  logic [W-1:0] any_t;
  assign any_t  = a_t | b_t;

  assign and_d  = a & b;
  assign or_d   = a | b;
  assign xor_d  = a ^ b;
  assign and_tc = any_t;
  assign or_tc  = any_t;
  assign xor_t  = any_t;
  assign and_tp = and_precise(a, a_t, b, b_t);
  assign or_tp  = or_precise(a, a_t, b, b_t);

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if ((!a[i] && !a_t[i]) || (!b[i] && !b_t[i])) begin
        AST_AND_TRUSTED_ZERO: assert (!and_tp[i] && !and_d[i]) else $error("and mask"); // R3
      end
      if ((a[i] && !a_t[i]) || (b[i] && !b_t[i])) begin
        AST_OR_TRUSTED_ONE: assert (!or_tp[i] && or_d[i]) else $error("or force"); // R4
      end
    end
    AST_BITWISE_SUBSET: assert (((and_tp & ~and_tc) | (or_tp & ~or_tc)) == '0) else $error("subset"); // R11
  end
endmodule

// File: rtl/tnt_mux_unit.sv
module tnt_mux_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] b,
  input  logic [W-1:0] b_t,
  input  logic         sel,
  input  logic         sel_t,
  output logic [W-1:0] d,
  output logic [W-1:0] tc,
  output logic [W-1:0] tp
);
  assign d  = sel ? b : a;
  assign tc = {W{sel_t}} | a_t | b_t;
  assign tp = sel ? b_t : a_t;

  always_comb begin
    if ((a_t | b_t) == '0) begin
      AST_MUX_CLEAN_DATA: assert (tp == '0) else $error("mux clean data"); // R7
    end
    if (sel_t) begin
      AST_MUX_SEL_TAINTS: assert (&tc) else $error("mux conservative sel"); // R6
    end
    AST_MUX_SUBSET: assert ((tp & ~tc) == '0) else $error("mux subset"); // R11
  end
endmodule

// File: rtl/tnt_add_unit.sv
module tnt_add_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] b,
  input  logic [W-1:0] b_t,
  output logic [W-1:0] d,
  output logic [W-1:0] tc,
  output logic [W-1:0] tp
);
  function automatic logic [W-1:0] wrap_sum(input logic [W-1:0] x, y);
    return x + y;
  endfunction

  logic [W-1:0] col_t;
  logic         any_t;

  assign col_t = a_t | b_t;
  assign any_t = |col_t;
  assign d     = wrap_sum(a, b);
  assign tc    = {W{any_t}};

  // A tainted column can reach every higher sum bit through the carry chain.
  assign tp[0] = col_t[0];
  for (genvar i = 1; i < W; i++) begin : g_prefix
    assign tp[i] = tp[i-1] | col_t[i];
  end

  always_comb begin
    AST_ADD_TOP_BIT: assert (tp[W-1] == any_t) else $error("add top bit"); // R8
    for (int i = 0; i + 1 < W; i++) begin
      AST_ADD_MONOTONE: assert (!tp[i] || tp[i+1]) else $error("add monotone"); // R8
    end
    AST_ADD_SUBSET: assert ((tp & ~tc) == '0) else $error("add subset"); // R11
  end
endmodule

// File: rtl/tnt_opdp.sv
module tnt_opdp
  import tnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_a_taint,
  input  logic [W-1:0]       op_b,
  input  logic [W-1:0]       op_b_taint,
  input  logic               sel,
  input  logic               sel_taint,
  input  logic [OP_BITS-1:0] opcode,
  input  logic               precise,
  output logic [W-1:0]       res,
  output logic [W-1:0]       res_taint
);
  logic [W-1:0] and_d, and_tc, and_tp, or_d, or_tc, or_tp, xor_d, xor_t;
  logic [W-1:0] mux_d, mux_tc, mux_tp, add_d, add_tc, add_tp;
  logic         op_known;
  logic         inputs_clean;

  tnt_bitwise_unit #(.W(W)) u_bitwise (
    .a(op_a), .a_t(op_a_taint), .b(op_b), .b_t(op_b_taint),
    .and_d(and_d), .and_tc(and_tc), .and_tp(and_tp),
    .or_d(or_d), .or_tc(or_tc), .or_tp(or_tp),
    .xor_d(xor_d), .xor_t(xor_t)
  );

  tnt_mux_unit #(.W(W)) u_mux (
    .a(op_a), .a_t(op_a_taint), .b(op_b), .b_t(op_b_taint),
    .sel(sel), .sel_t(sel_taint),
    .d(mux_d), .tc(mux_tc), .tp(mux_tp)
  );

  tnt_add_unit #(.W(W)) u_add (
    .a(op_a), .a_t(op_a_taint), .b(op_b), .b_t(op_b_taint),
    .d(add_d), .tc(add_tc), .tp(add_tp)
  );

  assign inputs_clean = ((op_a_taint | op_b_taint) == '0) && !sel_taint;

  always_comb begin
    res       = '0;
    res_taint = '0;
    op_known  = 1'b1;
    case (tnt_op_e'(opcode))
      OP_AND: begin res = and_d; res_taint = precise ? and_tp : and_tc; end
      OP_OR:  begin res = or_d;  res_taint = precise ? or_tp  : or_tc;  end
      OP_XOR: begin res = xor_d; res_taint = xor_t;                     end
      OP_MUX: begin res = mux_d; res_taint = precise ? mux_tp : mux_tc; end
      OP_ADD: begin res = add_d; res_taint = precise ? add_tp : add_tc; end
      default: op_known = 1'b0;
    endcase
  end

  always_comb begin
    if (!op_known) begin
      AST_UNUSED_OP_ZERO: assert (res == '0 && res_taint == '0) else $error("unused op"); // R10
    end
    if (inputs_clean) begin
      AST_CLEAN_IN_CLEAN_OUT: assert (res_taint == '0) else $error("clean inputs"); // R1
    end
  end
endmodule

// File: tb/tb_tnt_opdp.sv
`timescale 1ns/1ps
module tb_tnt_opdp;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] d;
    logic [W-1:0] t;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] op_a, op_a_taint, op_b, op_b_taint, res, res_taint;
  logic         sel, sel_taint, precise;
  logic [2:0]   opcode;

  tnt_opdp #(.W(W)) dut (
    .op_a(op_a), .op_a_taint(op_a_taint), .op_b(op_b), .op_b_taint(op_b_taint),
    .sel(sel), .sel_taint(sel_taint), .opcode(opcode), .precise(precise),
    .res(res), .res_taint(res_taint)
  );

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Bit-serial reference written from the requirements.
  function automatic exp_t model(input logic [W-1:0] a, at, b, bt,
                                 input logic s, st, input logic [2:0] op,
                                 input logic pr, input string tag);
    exp_t e;
    logic seen;
    logic any;
    e.d = '0; e.t = '0; e.tag = tag; seen = 0;
    any = ((at | bt) != '0);
    for (int i = 0; i < W; i++) begin
      case (op)
        3'd0: begin
          e.d[i] = a[i] & b[i];
          if (pr && ((!a[i] && !at[i]) || (!b[i] && !bt[i]))) e.t[i] = 0;
          else e.t[i] = at[i] | bt[i];
        end
        3'd1: begin
          e.d[i] = a[i] | b[i];
          if (pr && ((a[i] && !at[i]) || (b[i] && !bt[i]))) e.t[i] = 0;
          else e.t[i] = at[i] | bt[i];
        end
        3'd2: begin e.d[i] = a[i] ^ b[i]; e.t[i] = at[i] | bt[i]; end
        3'd3: begin
          e.d[i] = s ? b[i] : a[i];
          e.t[i] = pr ? (s ? bt[i] : at[i]) : (st | at[i] | bt[i]);
        end
        3'd4: begin
          seen = seen | at[i] | bt[i];
          e.t[i] = pr ? seen : any;
        end
        default: begin e.d[i] = 0; e.t[i] = 0; end
      endcase
    end
    if (op == 3'd4) e.d = W'(a + b);
    return e;
  endfunction

  task automatic drive(input logic [W-1:0] a, at, b, bt, input logic s, st,
                       input logic [2:0] op, input logic pr, input string tag);
    @(negedge clk);
    op_a = a; op_a_taint = at; op_b = b; op_b_taint = bt;
    sel = s; sel_taint = st; opcode = op; precise = pr;
    q.push_back(model(a, at, b, bt, s, st, op, pr, tag));
  endtask

  // Monitor: compares one result per rising edge, sampled 1 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (res !== e.d || res_taint !== e.t) begin
          n_fail++;
          $display("FAIL %s: res=%h taint=%h expected res=%h taint=%h",
                   e.tag, res, res_taint, e.d, e.t);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_a = '0; op_a_taint = '0; op_b = '0; op_b_taint = '0;
    sel = 0; sel_taint = 0; opcode = 3'd0; precise = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    drive('0, '0, '0, '0, 0, 0, 3'd0, 0, "R1 idle state");
    drive(16'hA5A5, '0, 16'h0FF0, '0, 1, 0, 3'd4, 1, "R1 clean add");
    drive(16'h1234, '0, 16'h5678, '0, 1, 0, 3'd3, 0, "R1 clean mux");
    // R2 conservative
    drive(16'h00FF, 16'h000F, 16'h0F0F, 16'h0100, 0, 0, 3'd0, 0, "R2 and cons");
    drive(16'h00FF, 16'h000F, 16'h0F0F, 16'h0100, 0, 0, 3'd1, 0, "R2 or cons");
    drive(16'h0001, 16'h8000, 16'h0001, '0, 0, 0, 3'd4, 0, "R2 add cons");
    // R3 precise AND: trusted zero masks tainted other side
    drive(16'h0000, '0, 16'hFFFF, 16'hFFFF, 0, 0, 3'd0, 1, "R3 and trusted zero");
    drive(16'hFF00, '0, 16'hF0F0, 16'hFFFF, 0, 0, 3'd0, 1, "R3 and mixed");
    // R4 precise OR
    drive(16'hFFFF, '0, 16'h0000, 16'hFFFF, 0, 0, 3'd1, 1, "R4 or trusted one");
    drive(16'h0F0F, 16'h00FF, 16'h3300, 16'hF000, 0, 0, 3'd1, 1, "R4 or mixed");
    // R5 XOR both policies
    drive(16'hAAAA, 16'h00F0, 16'h5555, 16'h0F00, 0, 0, 3'd2, 0, "R5 xor cons");
    drive(16'hAAAA, 16'h00F0, 16'h5555, 16'h0F00, 0, 0, 3'd2, 1, "R5 xor prec");
    // R6 / R7 mux
    drive(16'h1111, '0, 16'h2222, '0, 1, 1, 3'd3, 0, "R6 mux tainted sel cons");
    drive(16'h1111, '0, 16'h2222, '0, 1, 1, 3'd3, 1, "R7 mux tainted sel prec");
    drive(16'h1111, 16'h00F0, 16'h2222, 16'h0003, 0, 1, 3'd3, 1, "R7 mux picks a taint");
    drive(16'h1111, 16'h00F0, 16'h2222, 16'h0003, 1, 0, 3'd3, 1, "R7 mux picks b taint");
    // R8 add prefix
    drive(16'hFFFF, 16'h0010, 16'h0001, '0, 0, 0, 3'd4, 1, "R8 add prefix bit4");
    drive(16'h0000, 16'h8000, 16'h0000, '0, 0, 0, 3'd4, 1, "R8 add msb only");
    drive(16'h0000, '0, 16'h0000, 16'h0001, 0, 0, 3'd4, 1, "R8 add lsb");
    // R9 wraparound sum
    drive(16'hFFFF, '0, 16'h0002, '0, 0, 0, 3'd4, 0, "R9 add wrap");
    // R10 unused opcodes
    for (int k = 5; k < 8; k++)
      drive(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1, 3'(k), k[0], "R10 unused op");
    // R9 / R11 random vectors, each replayed under both policies
    for (int k = 0; k < 60; k++) begin
      logic [W-1:0] ra, rat, rb, rbt;
      logic [2:0]   rop;
      logic         rs, rst;
      ra = W'($urandom); rat = W'($urandom) & W'($urandom);
      rb = W'($urandom); rbt = W'($urandom) & W'($urandom);
      rop = 3'($urandom_range(0, 4)); rs = 1'($urandom); rst = 1'($urandom);
      drive(ra, rat, rb, rbt, rs, rst, rop, 0, "R9 random cons");
      drive(ra, rat, rb, rbt, rs, rst, rop, 1, "R11 random prec");
    end

    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule